// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM of 512K words by 8 bits. The host hands over one word-wide request at a time: a strobe, a read/write flag, a 19-bit address and, for writes, one data byte. The controller then drives the memory's active-low chip select, write enable and output enable, and its address. Each phase lasts long enough to meet the memory's minimum timings. When the cycle is over, the controller returns a one-clock completion pulse and, for reads, the captured byte.

All phase lengths come from elaboration-time parameters. These give the clock period and the memory's timing minimums in nanoseconds. Each length is a ceiling division with a floor of one clock, so the same code serves any speed grade and any clock.

A write starts with write enable low but the data bus released. The memory may still be driving its outputs for a short time after write enable falls, and the controller waits this out before it drives data. Write enable rises while chip select is still low. Data stays driven for one more clock after that.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe`, `busy` and `done` are 0.
- R2: A read request (`req`=1, `req_we`=0) sampled in idle drives the read encoding for RD+1 clocks. The read encoding is `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0. At the end of those clocks `mem_dq_in` is captured into `rsp_rdata`.
- R3: RD equals the largest of ceil(tRC/tCLK), ceil(tAA/tCLK) and ceil(tOE/tCLK), and is at least 1. `done` of a read is high in the (RD+2)th clock after the accepting edge.
- R4: A write request first holds `mem_we_n`=0 with `mem_dq_oe`=0 for WS = max(1, ceil(tWLQZ/tCLK)) clocks.
- R5: Next, `mem_dq_oe`=1 with `mem_dq_out` equal to the request data for WD clocks with `mem_we_n`=0. This is followed by one clock with `mem_we_n`=1 and the data still driven. WD is the largest of ceil(tDW), ceil(tWP)−WS, ceil(tCW)−WS, ceil(tAW)−WS and ceil(tWC)−WS−1, in clocks, and at least 1.
- R6: During a write, `mem_oe_n` stays 1 and `mem_cs_n` stays 0 until the clock after `mem_we_n` rises.
- R7: `done` is a single-clock pulse in the clock after the last memory phase. `busy` is 1 from the accepting edge until that clock.
- R8: A request presented while `busy` is 1 is ignored. No further memory cycle follows the current one.
- R9: A request held high through completion is accepted at the edge that ends the `done` clock. `mem_cs_n` is high for exactly that one clock between the two cycles.
- R10: `mem_addr` stays constant while `mem_cs_n` is 0 within one cycle.
- R11: `rsp_rdata` changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled while not busy |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last captured read data |
| busy | output | 1 | A memory cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The completion of one cycle and the acceptance of the next request can meet in the same clock. The `done` clock is also the idle clock in which a held request is sampled. The bench keeps `req` high across a write and changes the flag to read during the `done` clock. It then checks three things: chip select is high in that clock only, the read encoding appears in the very next clock, and the read returns the byte just written. A memory model in the bench returns valid data only after the read encoding has been held for RD clocks, so an early capture shows up as a wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACCESS,
        PH_RD_CAPTURE,
        PH_WR_SETUP,
        PH_WR_DRIVE,
        PH_WR_END
    } phase_e;

    // ceiling of ns / clk_ns
    function automatic int ns_to_clk(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_read_latch.sv
module sram_read_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (capture) data_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;

    // R11
    hold_between_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> $stable(dout));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 10,
    parameter int T_RC_NS    = 15,
    parameter int T_AA_NS    = 15,
    parameter int T_OE_NS    = 7,
    parameter int T_WLQZ_NS  = 7,
    parameter int T_DW_NS    = 8,
    parameter int T_WP_NS    = 12,
    parameter int T_CW_NS    = 13,
    parameter int T_AW_NS    = 12,
    parameter int T_WC_NS    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // phase lengths in clocks
    localparam int RD_CYC = at_least_one(max2(max2(ns_to_clk(T_RC_NS, CLK_NS),
                                                   ns_to_clk(T_AA_NS, CLK_NS)),
                                              ns_to_clk(T_OE_NS, CLK_NS)));
    localparam int WS_CYC = at_least_one(ns_to_clk(T_WLQZ_NS, CLK_NS));
    localparam int WD_CYC = at_least_one(max2(max2(ns_to_clk(T_DW_NS, CLK_NS),
                                                   ns_to_clk(T_WP_NS, CLK_NS) - WS_CYC),
                                              max2(max2(ns_to_clk(T_CW_NS, CLK_NS) - WS_CYC,
                                                        ns_to_clk(T_AW_NS, CLK_NS) - WS_CYC),
                                                   ns_to_clk(T_WC_NS, CLK_NS) - WS_CYC - 1)));
    localparam int MAX_LEN = max2(max2(RD_CYC, WS_CYC), WD_CYC);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              busy;
        logic              done;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rd_capture;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_read_latch #(.DATA_W(DATA_W)) u_rlatch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .din     (mem_dq_in),
        .dout    (rsp_rdata)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        rd_capture = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.busy  = 1'b1;
                    tmr_load    = 1'b1;
                    if (req_we) begin
                        ctl_d.phase = PH_WR_SETUP;
                        ctl_d.we_n  = 1'b0;
                        ctl_d.oe_n  = 1'b1;
                        tmr_val     = CNT_W'(WS_CYC - 1);
                    end else begin
                        ctl_d.phase = PH_RD_ACCESS;
                        ctl_d.we_n  = 1'b1;
                        ctl_d.oe_n  = 1'b0;
                        tmr_val     = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_RD_ACCESS: begin
                if (tmr_expired) ctl_d.phase = PH_RD_CAPTURE;
            end
            PH_RD_CAPTURE: begin
                rd_capture  = 1'b1;
                ctl_d.phase = PH_IDLE;
                ctl_d.cs_n  = 1'b1;
                ctl_d.oe_n  = 1'b1;
                ctl_d.busy  = 1'b0;
                ctl_d.done  = 1'b1;
            end
            PH_WR_SETUP: begin
                if (tmr_expired) begin
                    ctl_d.phase = PH_WR_DRIVE;
                    ctl_d.dq_oe = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(WD_CYC - 1);
                end
            end
            PH_WR_DRIVE: begin
                if (tmr_expired) begin
                    ctl_d.phase = PH_WR_END;
                    ctl_d.we_n  = 1'b1;
                end
            end
            PH_WR_END: begin
                ctl_d.phase = PH_IDLE;
                ctl_d.cs_n  = 1'b1;
                ctl_d.dq_oe = 1'b0;
                ctl_d.busy  = 1'b0;
                ctl_d.done  = 1'b1;
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_addr   = ctl_q.addr;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_oe  = ctl_q.dq_oe;
    assign busy       = ctl_q.busy;
    assign done       = ctl_q.done;

    // R6
    no_oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n));

    // R2
    read_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && !mem_dq_oe));

    // R4
    bus_released_at_we_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    // R5
    drive_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_cs_n);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
    localparam int CLK_NS = 4;
    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    // expected lengths from the requirements, grade numbers 15/15/7, 7, 8/12/13/12/15
    localparam int RD = cdiv(15);
    localparam int WS = cdiv(7);
    localparam int WD_A = (cdiv(8) > cdiv(13) - WS) ? cdiv(8) : cdiv(13) - WS;
    localparam int WD = (WD_A < 1) ? 1 : WD_A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
    logic        busy, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [18:0] mem_addr;
    int          nchk = 0, nerr = 0;
    logic [7:0]  last_rd = 8'h00;

    always #2 clk = ~clk;

    sram_cycle_ctrl #(.CLK_NS(CLK_NS)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model: 16 words by low address nibble, data valid after RD clocks of read
    logic [7:0] model [16];
    int         rd_age = 0;
    initial for (int i = 0; i < 16; i++) model[i] = 8'h50 + 8'(i);
    always @(posedge clk)
        if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
    always @(posedge mem_we_n)
        if (mem_cs_n === 1'b0 && mem_dq_oe === 1'b1) model[mem_addr[3:0]] <= mem_dq_out;
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && rd_age >= RD)
                       ? model[mem_addr[3:0]] : 8'hEE;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic txn(input logic wr, input logic [18:0] a, input logic [7:0] wd,
                       input logic [7:0] exp, input logic poke);
        int total = wr ? WS + WD + 2 : RD + 2;
        @(negedge clk);
        req = 1'b1; req_we = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        for (int n = 1; n <= total; n++) begin
            logic e_cs, e_we, e_oe, e_dq;
            if (poke && n == 2) begin req = 1'b1; req_we = ~wr; req_addr = a ^ 19'h1; end
            if (poke && n == 3) req = 1'b0;
            e_cs = (n < total) ? 1'b0 : 1'b1;
            if (wr) begin
                e_we = (n <= WS + WD) ? 1'b0 : 1'b1;
                e_oe = 1'b1;
                e_dq = (n > WS && n < total);
                chk(mem_cs_n == e_cs, "R6", "cs_n", mem_cs_n, e_cs);
                chk(mem_we_n == e_we, (n <= WS) ? "R4" : "R5", "we_n", mem_we_n, e_we);
                chk(mem_dq_oe == e_dq, (n <= WS) ? "R4" : "R5", "dq_oe", mem_dq_oe, e_dq);
                chk(mem_oe_n == e_oe, "R6", "oe_n", mem_oe_n, e_oe);
                if (e_dq) chk(mem_dq_out == wd, "R5", "dq_out", mem_dq_out, wd);
            end else begin
                e_oe = (n < total) ? 1'b0 : 1'b1;
                chk(mem_cs_n == e_cs, "R2", "cs_n", mem_cs_n, e_cs);
                chk(mem_oe_n == e_oe, "R2", "oe_n", mem_oe_n, e_oe);
                chk(mem_we_n == 1'b1 && mem_dq_oe == 1'b0, "R2", "we_n/dq_oe",
                    {mem_we_n, mem_dq_oe}, 2'b10);
            end
            chk(done == (n == total), wr ? "R7" : "R3", "done", done, (n == total));
            chk(busy == (n < total), "R7", "busy", busy, (n < total));
            if (n < total) chk(mem_addr == a, "R10", "mem_addr", mem_addr, a);
            if (n == total) begin
                if (wr) chk(rsp_rdata == last_rd, "R11", "rdata after write", rsp_rdata, last_rd);
                else    chk(rsp_rdata == exp, "R2", "rdata", rsp_rdata, exp);
            end
            @(negedge clk);
        end
        chk(mem_cs_n == 1'b1 && busy == 1'b0, "R8", "idle after cycle",
            {mem_cs_n, busy}, 2'b10);
        if (!wr) last_rd = exp;
    endtask

    typedef struct packed {
        logic        wr;
        logic [18:0] a;
        logic [7:0]  wd;
        logic [7:0]  exp;
        logic        poke;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 19'h00003, 8'h00, 8'h53, 1'b0},
        '{1'b1, 19'h7FFFF, 8'hA5, 8'h00, 1'b0},
        '{1'b1, 19'h00000, 8'h3C, 8'h00, 1'b1},
        '{1'b0, 19'h7FFFF, 8'h00, 8'hA5, 1'b0},
        '{1'b0, 19'h00000, 8'h00, 8'h3C, 1'b1},
        '{1'b1, 19'h12345, 8'hFF, 8'h00, 1'b0},
        '{1'b0, 19'h12345, 8'h00, 8'hFF, 1'b0},
        '{1'b1, 19'h2AAA6, 8'h00, 8'h00, 1'b0},
        '{1'b0, 19'h2AAA6, 8'h00, 8'h00, 1'b0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        // R1 during and after reset
        repeat (3) @(negedge clk);
        chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, done} == 6'b111000,
            "R1", "pins in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, done}, 6'b111000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, done} == 6'b111000,
            "R1", "pins idle", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, done}, 6'b111000);
        chk(rsp_rdata == 8'h00, "R1", "rdata reset", rsp_rdata, 0);

        foreach (VECS[i]) txn(VECS[i].wr, VECS[i].a, VECS[i].wd, VECS[i].exp, VECS[i].poke);

        // R9: write with request held, switch to read in the done clock
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 19'h00009; req_wdata = 8'h77;
        repeat (WS + WD + 2) @(negedge clk);
        chk(done == 1'b1 && mem_cs_n == 1'b1, "R9", "done clock gap",
            {done, mem_cs_n}, 2'b11);
        req_we = 1'b0;
        @(negedge clk);
        chk(mem_cs_n == 1'b0 && mem_oe_n == 1'b0, "R9", "next cycle starts",
            {mem_cs_n, mem_oe_n}, 2'b00);
        req = 1'b0;
        repeat (RD + 1) @(negedge clk);
        chk(done == 1'b1, "R9", "second done", done, 1);
        chk(rsp_rdata == 8'h77, "R9", "read back", rsp_rdata, 8'h77);
        @(negedge clk);
        chk(mem_cs_n == 1'b1 && !busy, "R8", "no third cycle", {mem_cs_n, busy}, 2'b10);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule